// File: doc/BRIEF.md
# Scrolling LED Matrix Row Scanner

This block refreshes a bicolour LED matrix of 64 columns by 8 rows that is driven through a chain of serial shift registers. A free-running tick timer opens one row slot every `TICK_CYCLES` clocks. In each slot the block:

- puts the row number on a 3-bit row select;
- shifts one bit per colour per column into the chain on a data line with a shift clock;
- raises the row and column enables to latch and light that row until the next slot.

Eight slots make one full refresh.

Pixel data lives in an external circular RAM of `BUF_BYTES` bytes, three display widths long. The block reads that RAM through a single read port with a one-cycle latency. Each row load shows a window of consecutive bytes that begins at a window base. The block scrolls the picture by moving that base forward by `SCROLL_STEP` bytes every `TICKS_PER_SCROLL` slots; the stored data is never copied. Both the window reads and the base advance wrap from the last byte of the buffer back to byte 0.

Top module: `led_scroll_scan`

## Requirements
- R1: During reset and until the first row slot opens, `row_en`, `col_en` and `ser_clk` stay low and `row_sel` is 0.
- R2: A new row slot opens every `TICK_CYCLES` clocks, the first one `TICK_CYCLES` clocks after reset is released. Slots take rows 0, 1, …, `NUM_ROWS-1` in order and then repeat. `row_sel` holds the slot's row number from the start of its load until the next slot opens.
- R3: Each row load produces exactly `NUM_COLS*COLOR_BITS` rising edges of `ser_clk`, one per bit. `ser_data` changes only while `ser_clk` is low, so it is stable at every rising edge.
- R4: Bit i of a load (the i-th rising edge, counted from 0) carries bit r of buffer byte (base + i) mod `BUF_BYTES`, where r is the slot's row number. `buf_rdata` must be valid one clock after `buf_addr` is presented.
- R5: `row_en` and `col_en` always move together. Both are low while a load is shifting. Both rise after the last bit's clock pulse and stay high until the next slot opens. `ser_clk` does not pulse while they are high.
- R6: For the k-th slot (k counted from 0 after reset), base = (`SCROLL_STEP` × floor(k / `TICKS_PER_SCROLL`)) mod `BUF_BYTES`. The base changes only when a slot opens, so a single load never mixes two scroll positions.
- R7: Reads whose window runs past byte `BUF_BYTES-1` continue at byte 0. The base also wraps to the start of the buffer, and `buf_addr` never leaves the range 0 to `BUF_BYTES-1`.
- R8: A row load, from the slot opening to the rise of the enables, takes `NUM_COLS*COLOR_BITS*(2+2*SHIFT_HALF)+1` clocks. With legal parameters it always ends before the next slot opens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_addr | output | $clog2(BUF_BYTES) | Read address into the frame RAM |
| buf_rdata | input | NUM_ROWS | RAM data, valid one clock after `buf_addr` |
| ser_data | output | 1 | Serial pixel data to the column shift chain |
| ser_clk | output | 1 | Shift clock; data is taken on its rising edge |
| row_sel | output | $clog2(NUM_ROWS) | Number of the row being loaded or lit |
| row_en | output | 1 | Row driver enable, high while the row is lit |
| col_en | output | 1 | Column latch/driver enable, high while the row is lit |

## Verification
A wrong window base or a broken wrap shows up as shifted pixel bits in the very first row load that uses that base. With random RAM contents, almost every bit position is then wrong within that load. A row counter that slips shows at once as a wrong `row_sel` and as data taken from the wrong bit of each byte. A lost or extra bit in the shift sequencer shows up as a wrong pulse count when the enables next rise. Timer faults show up as a wrong spacing between successive enable rises. The bench uses a reduced display geometry and fast scroll settings so that both the window wrap and the base wrap occur within a short run. Meanwhile the RAM contents keep changing between rows.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

    // Sequencer states for one row load
    typedef enum logic [2:0] {
        SH_IDLE = 3'd0,   // after reset, before the first slot
        SH_ADDR = 3'd1,   // address presented to RAM
        SH_WAIT = 3'd2,   // RAM data arriving
        SH_LOW  = 3'd3,   // data driven, shift clock low
        SH_HIGH = 3'd4,   // shift clock high
        SH_SHOW = 3'd5    // row lit until next slot
    } shift_state_e;

    // Width of a counter that must hold values 0..n-1, at least one bit
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Add a step to an index of a circular buffer, wrapping once
    function automatic int unsigned ring_add(input int unsigned idx,
                                             input int unsigned step,
                                             input int unsigned size);
        int unsigned s;
        s = idx + step;
        return (s >= size) ? s - size : s;
    endfunction

endpackage

// File: rtl/scan_timer.sv
module scan_timer
    import led_scan_pkg::*;
#(
    parameter int unsigned TICK_CYCLES      = 200000,
    parameter int unsigned NUM_ROWS         = 8,
    parameter int unsigned BUF_BYTES        = 384,
    parameter int unsigned SCROLL_STEP      = 2,
    parameter int unsigned TICKS_PER_SCROLL = 100,
    localparam int unsigned TW = cnt_width(TICK_CYCLES),
    localparam int unsigned RW = cnt_width(NUM_ROWS),
    localparam int unsigned AW = cnt_width(BUF_BYTES),
    localparam int unsigned SW = cnt_width(TICKS_PER_SCROLL)
) (
    input  logic          clk,
    input  logic          rst,
    output logic          tick_o,
    output logic [RW-1:0] row_o,
    output logic [AW-1:0] base_o
);

    logic [TW-1:0] tick_cnt;
    logic [RW-1:0] row_q;
    logic [AW-1:0] base_q;
    logic [SW-1:0] scroll_cnt;
    logic [AW-1:0] base_next;

    assign tick_o = (tick_cnt == TW'(TICK_CYCLES - 1));
    assign row_o  = row_q;
    assign base_o = base_q;

    always_comb begin
        base_next = AW'(ring_add(int'(base_q), SCROLL_STEP, BUF_BYTES));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt   <= '0;
            row_q      <= '0;
            base_q     <= '0;
            scroll_cnt <= '0;
        end else begin
            if (tick_o) begin
                tick_cnt <= '0;
                row_q    <= (row_q == RW'(NUM_ROWS - 1)) ? '0 : row_q + 1'b1;
                if (scroll_cnt == SW'(TICKS_PER_SCROLL - 1)) begin
                    scroll_cnt <= '0;
                    base_q     <= base_next;
                end else begin
                    scroll_cnt <= scroll_cnt + 1'b1;
                end
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

    // Base and row move only when a slot opens
    assert_base_only_at_tick_R6: assert property (@(posedge clk) disable iff (rst)
        !tick_o |=> $stable(base_q));
    assert_row_only_at_tick_R2: assert property (@(posedge clk) disable iff (rst)
        !tick_o |=> $stable(row_q));
    assert_base_in_range_R7: assert property (@(posedge clk) disable iff (rst)
        base_q < AW'(BUF_BYTES));

endmodule

// File: rtl/row_shifter.sv
module row_shifter
    import led_scan_pkg::*;
#(
    parameter int unsigned NUM_ROWS   = 8,
    parameter int unsigned BUF_BYTES  = 384,
    parameter int unsigned ROW_BITS   = 128,
    parameter int unsigned SHIFT_HALF = 4,
    localparam int unsigned RW = cnt_width(NUM_ROWS),
    localparam int unsigned AW = cnt_width(BUF_BYTES),
    localparam int unsigned BW = cnt_width(ROW_BITS),
    localparam int unsigned PW = cnt_width(SHIFT_HALF)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_i,
    input  logic [RW-1:0]       row_i,
    input  logic [AW-1:0]       base_i,
    output logic [AW-1:0]       rd_addr_o,
    input  logic [NUM_ROWS-1:0] rd_data_i,
    output logic                ser_data_o,
    output logic                ser_clk_o,
    output logic [RW-1:0]       row_sel_o,
    output logic                lit_o
);

    shift_state_e  state;
    logic [BW-1:0] bit_idx;
    logic [PW-1:0] phase;
    logic          phase_done;
    logic          last_bit;
    logic [AW-1:0] addr_next;

    assign phase_done = (phase == PW'(SHIFT_HALF - 1));
    assign last_bit   = (bit_idx == BW'(ROW_BITS - 1));

    always_comb begin
        addr_next = AW'(ring_add(int'(rd_addr_o), 1, BUF_BYTES));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SH_IDLE;
            bit_idx    <= '0;
            phase      <= '0;
            rd_addr_o  <= '0;
            ser_data_o <= 1'b0;
            ser_clk_o  <= 1'b0;
            row_sel_o  <= '0;
            lit_o      <= 1'b0;
        end else if (tick_i) begin
            // open a new slot: latch row and window base, darken the row
            state     <= SH_ADDR;
            row_sel_o <= row_i;
            rd_addr_o <= base_i;
            bit_idx   <= '0;
            phase     <= '0;
            ser_clk_o <= 1'b0;
            lit_o     <= 1'b0;
        end else begin
            unique case (state)
                SH_ADDR: state <= SH_WAIT;
                SH_WAIT: begin
                    ser_data_o <= rd_data_i[row_sel_o];
                    phase      <= '0;
                    state      <= SH_LOW;
                end
                SH_LOW: begin
                    if (phase_done) begin
                        ser_clk_o <= 1'b1;
                        phase     <= '0;
                        state     <= SH_HIGH;
                    end else begin
                        phase <= phase + 1'b1;
                    end
                end
                SH_HIGH: begin
                    if (phase_done) begin
                        ser_clk_o <= 1'b0;
                        phase     <= '0;
                        if (last_bit) begin
                            state <= SH_SHOW;
                            lit_o <= 1'b1;
                        end else begin
                            bit_idx   <= bit_idx + 1'b1;
                            rd_addr_o <= addr_next;
                            state     <= SH_ADDR;
                        end
                    end else begin
                        phase <= phase + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // A new slot must never cut a load short
    assert_load_done_before_tick_R8: assert property (@(posedge clk) disable iff (rst)
        tick_i |-> (state == SH_IDLE || state == SH_SHOW));
    // No shift clock activity while a row is lit
    assert_no_clock_while_lit_R5: assert property (@(posedge clk) disable iff (rst)
        lit_o |-> !ser_clk_o);
    // Data is settled at every rising shift edge
    assert_data_stable_at_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_clk_o) |-> $stable(ser_data_o));
    // Row select holds between slot openings
    assert_row_sel_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(row_sel_o));
    // Read address stays inside the buffer
    assert_addr_in_range_R7: assert property (@(posedge clk) disable iff (rst)
        rd_addr_o < AW'(BUF_BYTES));

endmodule

// File: rtl/led_scroll_scan.sv
module led_scroll_scan
    import led_scan_pkg::*;
#(
    parameter int unsigned NUM_COLS         = 64,
    parameter int unsigned NUM_ROWS         = 8,
    parameter int unsigned COLOR_BITS       = 2,
    parameter int unsigned BUF_BYTES        = 384,
    parameter int unsigned SCROLL_STEP      = 2,
    parameter int unsigned TICKS_PER_SCROLL = 100,
    parameter int unsigned TICK_CYCLES      = 200000,
    parameter int unsigned SHIFT_HALF       = 4,
    localparam int unsigned ROW_BITS = NUM_COLS * COLOR_BITS,
    localparam int unsigned AW       = cnt_width(BUF_BYTES),
    localparam int unsigned RW       = cnt_width(NUM_ROWS)
) (
    input  logic                clk,
    input  logic                rst,
    output logic [AW-1:0]       buf_addr,
    input  logic [NUM_ROWS-1:0] buf_rdata,
    output logic                ser_data,
    output logic                ser_clk,
    output logic [RW-1:0]       row_sel,
    output logic                row_en,
    output logic                col_en
);

    logic          tick;
    logic [RW-1:0] slot_row;
    logic [AW-1:0] slot_base;
    logic          lit;

    scan_timer #(
        .TICK_CYCLES     (TICK_CYCLES),
        .NUM_ROWS        (NUM_ROWS),
        .BUF_BYTES       (BUF_BYTES),
        .SCROLL_STEP     (SCROLL_STEP),
        .TICKS_PER_SCROLL(TICKS_PER_SCROLL)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .tick_o(tick),
        .row_o (slot_row),
        .base_o(slot_base)
    );

    row_shifter #(
        .NUM_ROWS  (NUM_ROWS),
        .BUF_BYTES (BUF_BYTES),
        .ROW_BITS  (ROW_BITS),
        .SHIFT_HALF(SHIFT_HALF)
    ) u_shifter (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .row_i     (slot_row),
        .base_i    (slot_base),
        .rd_addr_o (buf_addr),
        .rd_data_i (buf_rdata),
        .ser_data_o(ser_data),
        .ser_clk_o (ser_clk),
        .row_sel_o (row_sel),
        .lit_o     (lit)
    );

    assign row_en = lit;
    assign col_en = lit;

    assert_enables_paired_R5: assert property (@(posedge clk) disable iff (rst)
        row_en == col_en);
    assert_dark_on_slot_open_R5: assert property (@(posedge clk) disable iff (rst)
        tick |=> !row_en);

endmodule

// File: tb/led_scroll_scan_bench.sv
`timescale 1ns/1ps
module led_scroll_scan_bench;

    localparam int NUM_COLS = 32;
    localparam int NUM_ROWS = 8;
    localparam int COLOR_BITS = 2;
    localparam int BUF_BYTES = 192;
    localparam int SCROLL_STEP = 2;
    localparam int TPS = 3;
    localparam int TICK_CYCLES = 300;
    localparam int SHIFT_HALF = 1;
    localparam int ROW_BITS = NUM_COLS * COLOR_BITS;   // 64
    localparam int AW = $clog2(BUF_BYTES);
    localparam int RW = $clog2(NUM_ROWS);
    localparam int NLOADS = 300;                       // base wraps at slot 288
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [AW-1:0] buf_addr;
    logic [NUM_ROWS-1:0] buf_rdata;
    logic ser_data, ser_clk, row_en, col_en;
    logic [RW-1:0] row_sel;

    always #2.5 clk = ~clk;

    led_scroll_scan #(
        .NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS), .COLOR_BITS(COLOR_BITS),
        .BUF_BYTES(BUF_BYTES), .SCROLL_STEP(SCROLL_STEP), .TICKS_PER_SCROLL(TPS),
        .TICK_CYCLES(TICK_CYCLES), .SHIFT_HALF(SHIFT_HALF)
    ) u_led_scroll_scan (
        .clk(clk), .rst(rst), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
        .ser_data(ser_data), .ser_clk(ser_clk), .row_sel(row_sel),
        .row_en(row_en), .col_en(col_en)
    );

    // Frame RAM model: one-cycle read latency
    logic [NUM_ROWS-1:0] mem [BUF_BYTES];
    always @(posedge clk) buf_rdata <= mem[buf_addr];

    int tests = 0;
    int fails = 0;
    int nbits = 0;
    int loads = 0;
    logic [ROW_BITS-1:0] got;
    realtime last_lit;

    task automatic check(input bit ok, input string req,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_base(input int k);
        return (SCROLL_STEP * (k / TPS)) % BUF_BYTES;
    endfunction

    function automatic logic [ROW_BITS-1:0] exp_row(input int k);
        logic [ROW_BITS-1:0] v;
        int b, r;
        b = exp_base(k);
        r = k % NUM_ROWS;
        for (int i = 0; i < ROW_BITS; i++) v[i] = mem[(b + i) % BUF_BYTES][r];
        return v;
    endfunction

    // Receiving shift chain
    always @(posedge ser_clk) begin
        if (row_en) check(1'b0, "R5 clock pulse while lit", 1, 0);
        if (nbits < ROW_BITS) got[nbits] = ser_data;
        nbits++;
    end

    always @(negedge row_en) nbits = 0;

    // One check group per displayed row
    always @(posedge row_en) begin
        #1;
        check(nbits == ROW_BITS, "R3 bit count", nbits, ROW_BITS);
        check(col_en == 1'b1, "R5 col_en with row_en", col_en, 1);
        check(int'(row_sel) == loads % NUM_ROWS, "R2 row order", row_sel, loads % NUM_ROWS);
        if (loads > 0)
            check((($realtime - last_lit) == TICK_CYCLES * 5.0), "R2 slot period",
                  longint'($realtime - last_lit), TICK_CYCLES * 5);
        if (exp_base(loads) + ROW_BITS > BUF_BYTES)
            check(got == exp_row(loads), "R7 wrapped window data", got, exp_row(loads));
        else
            check(got == exp_row(loads), "R4 R6 window data", got, exp_row(loads));
        last_lit = $realtime;
        loads++;
        // new picture content between rows
        for (int j = 0; j < 4; j++) mem[$urandom % BUF_BYTES] = NUM_ROWS'($urandom);
        if (loads == 100) for (int j = 0; j < BUF_BYTES; j++) mem[j] = '1;
        if (loads == 108) for (int j = 0; j < BUF_BYTES; j++) mem[j] = '0;
        if (loads == 116) for (int j = 0; j < BUF_BYTES; j++) mem[j] = NUM_ROWS'($urandom);
    end

    initial begin
        int cyc;
        void'($urandom(32'd1729));
        for (int j = 0; j < BUF_BYTES; j++) mem[j] = NUM_ROWS'($urandom);
        repeat (4) @(posedge clk);
        #1;
        check(!row_en && !col_en && !ser_clk && row_sel == 0, "R1 in reset",
              {row_en, col_en, ser_clk}, 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (TICK_CYCLES - 3) @(negedge clk);
        check(!row_en && !col_en && nbits == 0 && row_sel == 0, "R1 before first slot",
              {row_en, col_en, 8'(nbits)}, 0);
        cyc = 0;
        while (loads < NLOADS && cyc < WATCHDOG) begin
            @(negedge clk);
            cyc++;
        end
        if (loads < NLOADS) check(1'b0, "R2 watchdog expired", loads, NLOADS);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule